// File: doc/BRIEF.md
# Watchdog Timer With Reset Or Wake Outcome

This block is a watchdog that counts a slow, low-power tick (nominally 32 kHz) delivered as a single-cycle enable in the system clock domain. The tick first passes through a prescaler that divides it by 32 or by 128. A power-of-two postscaler follows, with ratios from 1:1 up to 1:32,768 picked by a 4-bit select. With a 32 kHz tick, the total timeout spans roughly 1 ms to 131 s.

The watchdog is enabled in one of two ways. A hardware configuration bit can force it on permanently. Otherwise, a software control bit turns it on, and a device reset clears that bit. Five events restart the count: the device reset, a clear-watchdog pulse, entry into a power-save mode, exit from sleep or idle, and completion of a clock switch. When the count expires in normal run mode, the block issues a reset request. When it expires during sleep or idle, the block issues a wake request instead. Either outcome sets a sticky flag that only an explicit software clear removes, and a device reset does not clear it. A separate output keeps the slow tick source running whenever the watchdog is enabled.

Top module: `wake_watchdog`

## Requirements
- R1: The prescaler divides the tick by 32 when `pre_long` is 0 and by 128 when `pre_long` is 1.
- R2: With postscaler select N (0 to 15) and prescaler ratio P, a timeout happens on the P*2^N-th tick after the last restart.
- R3: When `hw_force_en` is 1, the watchdog runs regardless of the software enable bit.
- R4: When `hw_force_en` is 0, the watchdog runs only while the software enable bit is 1. That bit is written with `sw_en_wdata` on a `sw_en_wr` cycle and is cleared by `rst`. While the watchdog is disabled, both counts are held at zero.
- R5: Each of `rst`, `kick`, `lp_enter`, `lp_exit` and `clk_sw_done` zeroes both counts, so a full period of ticks is needed after it.
- R6: A timeout while `in_lowpower` is 0 raises `rst_req` for exactly one cycle, in the cycle after the clock edge that took the terminal tick. Both counts then restart from zero.
- R7: A timeout while `in_lowpower` is 1 raises `wake_req` instead of `rst_req`. The two requests are never high together.
- R8: Any timeout sets `timeout_flag`. The flag stays set through later timeouts and through `rst`, and it is cleared only by `flag_clr`. A timeout wins over `flag_clr` in the same cycle. The flag is 0 from configuration.
- R9: `osc_en` is the registered enable: it follows `hw_force_en | software bit` one cycle later and is 0 while `rst` is high.
- R10: A restart event in the same cycle as the terminal tick suppresses that timeout.
- R11: Changes to `pre_long` and `post_sel` take effect only at the next restart or timeout.
- R12: After reset, `rst_req`, `wake_req` and `timeout_flag` are 0, and with `hw_force_en` at 0 `osc_en` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high device reset |
| tick_en | input | 1 | One-cycle pulse per slow tick |
| hw_force_en | input | 1 | Configuration bit forcing the watchdog on |
| sw_en_wr | input | 1 | Write strobe for the software enable bit |
| sw_en_wdata | input | 1 | Value written to the software enable bit |
| pre_long | input | 1 | Prescaler mode: 0 divides by 32, 1 divides by 128 |
| post_sel | input | 4 | Postscaler exponent N, ratio 2^N |
| kick | input | 1 | Clear-watchdog pulse |
| lp_enter | input | 1 | Power-save entry pulse |
| lp_exit | input | 1 | Sleep or idle exit pulse |
| clk_sw_done | input | 1 | Clock-switch completion pulse |
| in_lowpower | input | 1 | Level: device is in sleep or idle |
| flag_clr | input | 1 | Software clear of the timeout flag |
| rst_req | output | 1 | One-cycle reset request |
| wake_req | output | 1 | One-cycle wake request |
| timeout_flag | output | 1 | Sticky timeout indicator |
| osc_en | output | 1 | Keeps the slow tick source running |

## Verification
The hardest case to reach is a restart event that lands in the same cycle as the terminal tick. This requires knowing the exact tick count since the last restart. The stimulus starts every scenario with its own clear and counts ticks one per clock, then drives a clear-watchdog pulse on precisely the P*2^N-th tick. The latching of mode and select is reached in a similar way: the settings change mid-period without a clear, the first timeout is measured at the old period, and the following one at the new period.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
  typedef enum logic [1:0] {
    OUT_NONE  = 2'd0,
    OUT_RESET = 2'd1,
    OUT_WAKE  = 2'd2
  } wdg_outcome_t;
endpackage

// File: rtl/wdg_enable.sv
module wdg_enable (
  input  logic clk,
  input  logic rst,
  input  logic hw_en,
  input  logic sw_wr,
  input  logic sw_data,
  output logic en,
  output logic osc_en
);
  logic sw_q;

  always_ff @(posedge clk) begin
    if (rst) sw_q <= 1'b0;
    else if (sw_wr) sw_q <= sw_data;
  end

  assign en = hw_en | sw_q;

  always_ff @(posedge clk) begin
    if (rst) osc_en <= 1'b0;
    else osc_en <= en;
  end

  // R3: forced enable keeps the tick source on
  assert_hw_on_R3: assert property (@(posedge clk) disable iff (rst)
    hw_en |=> osc_en);
endmodule

// File: rtl/wdg_prescaler.sv
module wdg_prescaler #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic long_sel,
  output logic tc
);
  localparam int CW = LONG_LOG2;
  localparam logic [CW-1:0] SHORT_LAST = CW'((1 << SHORT_LOG2) - 1);

  logic          long_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] last;

  always_comb last = long_q ? {CW{1'b1}} : SHORT_LAST;
  assign tc = tick & (cnt_q == last);

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q  <= '0;
      long_q <= long_sel;
    end else if (tick) begin
      cnt_q <= tc ? '0 : cnt_q + 1'b1;
    end
  end

  // R1: count never passes the selected ratio
  assert_pre_bound_R1: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
endmodule

// File: rtl/wdg_postscaler.sv
module wdg_postscaler #(
  parameter int SEL_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             step,
  input  logic [SEL_W-1:0] sel,
  output logic             tc
);
  localparam int POST_W = (1 << SEL_W) - 1;

  logic [SEL_W-1:0]  sel_q;
  logic [POST_W-1:0] cnt_q;
  logic [POST_W-1:0] last;

  always_comb last = ~({POST_W{1'b1}} << sel_q);
  assign tc = step & (cnt_q == last);

  always_ff @(posedge clk) begin
    if (restart) begin
      cnt_q <= '0;
      sel_q <= sel;
    end else if (step) begin
      cnt_q <= tc ? '0 : cnt_q + 1'b1;
    end
  end

  // R2: count stays inside the 2^N window latched at restart
  assert_post_bound_R2: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last);
endmodule

// File: rtl/wake_watchdog.sv
module wake_watchdog #(
  parameter int SHORT_LOG2 = 5,
  parameter int LONG_LOG2  = 7,
  parameter int SEL_W      = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_en,
  input  logic             hw_force_en,
  input  logic             sw_en_wr,
  input  logic             sw_en_wdata,
  input  logic             pre_long,
  input  logic [SEL_W-1:0] post_sel,
  input  logic             kick,
  input  logic             lp_enter,
  input  logic             lp_exit,
  input  logic             clk_sw_done,
  input  logic             in_lowpower,
  input  logic             flag_clr,
  output logic             rst_req,
  output logic             wake_req,
  output logic             timeout_flag,
  output logic             osc_en
);
  import wdg_pkg::*;

  logic         en;
  logic         clr_any;
  logic         timeout;
  logic         restart;
  logic         pre_tc;
  logic         post_tc;
  wdg_outcome_t outcome;
  logic         flag_q = 1'b0;

  wdg_enable u_enable (
    .clk    (clk),
    .rst    (rst),
    .hw_en  (hw_force_en),
    .sw_wr  (sw_en_wr),
    .sw_data(sw_en_wdata),
    .en     (en),
    .osc_en (osc_en)
  );

  assign clr_any = rst | kick | lp_enter | lp_exit | clk_sw_done;
  assign timeout = en & post_tc & ~clr_any;
  assign restart = clr_any | ~en | timeout;

  wdg_prescaler #(.SHORT_LOG2(SHORT_LOG2), .LONG_LOG2(LONG_LOG2)) u_pre (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick_en),
    .long_sel(pre_long),
    .tc      (pre_tc)
  );

  wdg_postscaler #(.SEL_W(SEL_W)) u_post (
    .clk    (clk),
    .rst    (rst),
    .restart(restart),
    .step   (pre_tc),
    .sel    (post_sel),
    .tc     (post_tc)
  );

  always_comb begin
    outcome = OUT_NONE;
    if (timeout) outcome = in_lowpower ? OUT_WAKE : OUT_RESET;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_req  <= 1'b0;
      wake_req <= 1'b0;
    end else begin
      rst_req  <= (outcome == OUT_RESET);
      wake_req <= (outcome == OUT_WAKE);
    end
  end

  // flag is not touched by rst so it survives the reset it provokes
  always_ff @(posedge clk) begin
    if (timeout) flag_q <= 1'b1;
    else if (flag_clr) flag_q <= 1'b0;
  end
  assign timeout_flag = flag_q;

  // R6: reset request is a single-cycle pulse
  assert_rst_pulse_R6: assert property (@(posedge clk) disable iff (rst)
    rst_req |=> !rst_req);
  // R7: never both outcomes at once
  assert_one_kind_R7: assert property (@(posedge clk) disable iff (rst)
    !(rst_req && wake_req));
  // R8: every request is accompanied by the sticky flag
  assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
    (rst_req || wake_req) |-> timeout_flag);
  // R10: a restart event suppresses any request in the next cycle
  assert_clear_wins_R10: assert property (@(posedge clk) disable iff (rst)
    (kick || lp_enter || lp_exit || clk_sw_done) |=> !(rst_req || wake_req));
endmodule

// File: tb/wake_watchdog_tb_top.sv
module wake_watchdog_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick_en = 1'b0;
  logic       hw_force_en = 1'b0;
  logic       sw_en_wr = 1'b0;
  logic       sw_en_wdata = 1'b0;
  logic       pre_long = 1'b0;
  logic [3:0] post_sel = 4'd0;
  logic       kick = 1'b0;
  logic       lp_enter = 1'b0;
  logic       lp_exit = 1'b0;
  logic       clk_sw_done = 1'b0;
  logic       in_lowpower = 1'b0;
  logic       flag_clr = 1'b0;
  logic       rst_req, wake_req, timeout_flag, osc_en;

  int n_tests = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  wake_watchdog dut_i (
    .clk(clk), .rst(rst), .tick_en(tick_en), .hw_force_en(hw_force_en),
    .sw_en_wr(sw_en_wr), .sw_en_wdata(sw_en_wdata), .pre_long(pre_long),
    .post_sel(post_sel), .kick(kick), .lp_enter(lp_enter), .lp_exit(lp_exit),
    .clk_sw_done(clk_sw_done), .in_lowpower(in_lowpower), .flag_clr(flag_clr),
    .rst_req(rst_req), .wake_req(wake_req), .timeout_flag(timeout_flag),
    .osc_en(osc_en)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cyc();
    cyc();
    rst = 1'b0;
  endtask

  // one clear pulse on the kick input, no tick
  task automatic do_kick();
    kick = 1'b1;
    tick_en = 1'b0;
    cyc();
    kick = 1'b0;
  endtask

  // ticks every cycle until a request appears; n = ticks taken
  task automatic count_to(output int n, output int got_wake);
    n = 0;
    got_wake = 0;
    tick_en = 1'b1;
    for (int i = 0; i < 5000; i++) begin
      cyc();
      n++;
      if (rst_req || wake_req) begin
        got_wake = wake_req;
        break;
      end
    end
    tick_en = 1'b0;
  endtask

  task automatic run_ticks(input int k, output int seen);
    seen = 0;
    tick_en = 1'b1;
    for (int i = 0; i < k; i++) begin
      cyc();
      if (rst_req || wake_req) seen = 1;
    end
    tick_en = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R12 rst_req", rst_req, 0);
    chk("R12 wake_req", wake_req, 0);
    chk("R12 flag", timeout_flag, 0);
    chk("R12 osc_en", osc_en, 0);
  endtask

  task automatic t_prescale();
    int n, w;
    hw_force_en = 1'b1;
    post_sel = 4'd0;
    pre_long = 1'b0;
    do_kick();
    count_to(n, w);
    chk("R1 div32", n, 32);
    chk("R6 rst_req high", rst_req, 1);
    cyc();
    chk("R6 pulse one cycle", rst_req, 0);
    pre_long = 1'b1;
    do_kick();
    count_to(n, w);
    chk("R1 div128", n, 128);
  endtask

  task automatic t_postscale();
    int n, w;
    pre_long = 1'b0;
    post_sel = 4'd3;
    do_kick();
    count_to(n, w);
    chk("R2 32x8", n, 256);
    post_sel = 4'd5;
    do_kick();
    count_to(n, w);
    chk("R2 32x32", n, 1024);
    pre_long = 1'b1;
    post_sel = 4'd2;
    do_kick();
    count_to(n, w);
    chk("R2 128x4", n, 512);
  endtask

  task automatic t_flag();
    int n, w;
    chk("R8 flag after timeouts", timeout_flag, 1);
    do_reset();
    chk("R8 flag survives rst", timeout_flag, 1);
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
    chk("R8 flag cleared", timeout_flag, 0);
    hw_force_en = 1'b1;
    pre_long = 1'b0;
    post_sel = 4'd0;
    do_kick();
    run_ticks(31, w);
    flag_clr = 1'b1;
    count_to(n, w);
    flag_clr = 1'b0;
    chk("R8 timeout beats flag_clr", timeout_flag, 1);
    flag_clr = 1'b1;
    cyc();
    flag_clr = 1'b0;
  endtask

  task automatic t_enable();
    int n, w, seen;
    hw_force_en = 1'b0;
    do_reset();
    pre_long = 1'b0;
    post_sel = 4'd0;
    run_ticks(100, seen);
    chk("R4 disabled no request", seen, 0);
    chk("R9 osc_en off", osc_en, 0);
    sw_en_wr = 1'b1;
    sw_en_wdata = 1'b1;
    cyc();
    sw_en_wr = 1'b0;
    cyc();
    chk("R9 osc_en follows sw", osc_en, 1);
    do_kick();
    count_to(n, w);
    chk("R4 sw enabled period", n, 32);
    hw_force_en = 1'b1;
    sw_en_wr = 1'b1;
    sw_en_wdata = 1'b0;
    cyc();
    sw_en_wr = 1'b0;
    do_kick();
    count_to(n, w);
    chk("R3 hw forces run", n, 32);
    hw_force_en = 1'b0;
    cyc();
    chk("R9 osc_en drops", osc_en, 0);
    sw_en_wr = 1'b1;
    sw_en_wdata = 1'b1;
    cyc();
    sw_en_wr = 1'b0;
    do_reset();
    cyc();
    chk("R4 rst clears sw bit", osc_en, 0);
  endtask

  task automatic pulse_src(input int which);
    tick_en = 1'b1;
    case (which)
      0: kick = 1'b1;
      1: lp_enter = 1'b1;
      2: lp_exit = 1'b1;
      default: clk_sw_done = 1'b1;
    endcase
    cyc();
    kick = 1'b0;
    lp_enter = 1'b0;
    lp_exit = 1'b0;
    clk_sw_done = 1'b0;
    tick_en = 1'b0;
  endtask

  task automatic t_clear_sources();
    int n, w, seen;
    hw_force_en = 1'b1;
    pre_long = 1'b0;
    post_sel = 4'd0;
    for (int s = 0; s < 4; s++) begin
      do_kick();
      run_ticks(20, seen);
      pulse_src(s);
      count_to(n, w);
      chk($sformatf("R5 source %0d restarts", s), n, 32);
    end
    do_kick();
    run_ticks(20, seen);
    do_reset();
    count_to(n, w);
    chk("R5 rst restarts", n, 32);
  endtask

  task automatic t_priority();
    int n, w, seen;
    do_kick();
    run_ticks(31, seen);
    chk("R10 no early request", seen, 0);
    kick = 1'b1;
    tick_en = 1'b1;
    cyc();
    kick = 1'b0;
    tick_en = 1'b0;
    chk("R10 terminal suppressed", rst_req | wake_req, 0);
    count_to(n, w);
    chk("R10 fresh period", n, 32);
  endtask

  task automatic t_wake();
    int n, w;
    in_lowpower = 1'b1;
    do_kick();
    count_to(n, w);
    chk("R7 wake period", n, 32);
    chk("R7 wake chosen", w, 1);
    chk("R7 no reset", rst_req, 0);
    in_lowpower = 1'b0;
  endtask

  task automatic t_latch();
    int n, w;
    pre_long = 1'b0;
    post_sel = 4'd0;
    do_kick();
    pre_long = 1'b1;
    post_sel = 4'd2;
    count_to(n, w);
    chk("R11 old settings kept", n, 32);
    count_to(n, w);
    chk("R11 new settings at restart", n, 512);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_postscale();
    t_flag();
    t_enable();
    t_clear_sources();
    t_priority();
    t_wake();
    t_latch();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule